// File: doc/BRIEF.md
# Byte-Mapped Audio Frame Demultiplexer

This block takes one multichannel audio stream and splits each frame into four byte streams. It first gathers a whole input frame into a local byte buffer. A programmable routing table of 64 byte slots then decides, for every output byte slot, which byte of that buffered frame it carries. Slots 0 to 15 belong to output lane 0, slots 16 to 31 to lane 1, and so on for lanes 2 and 3. Each slot has its own enable, and each lane can be switched on or off as a whole.

Configuration goes through a small word-wide write port. The input is a valid/ready stream of samples of 8, 16 or 32 bits, with a start-of-frame flag. Each output lane is a valid/ready byte stream with an end-of-frame marker. A global enable gates the input. A self-clearing soft reset returns the control logic to its idle, disabled state, and an activity status shows when the block has drained.

Top module: `byte_route_demux`

## Requirements
- R1: Register 21 sets the input format: bits [1:0] give the sample width (0 = 8 bits, 1 = 16 bits, 2 = 32 bits) and bits [7:4] give the channel count minus one. Each sample adds its bytes to the frame least significant byte first, so the frame is channels × bytes-per-sample bytes long, and any unused high bytes of `in_data` are ignored.
- R2: The map is held in registers 0 to 15. Slot s lives in register s/4, bits 8·(s mod 4) upward. Slot s belongs to lane s/16, and when emitted it carries the frame byte at the offset held in its map entry.
- R3: Slot enables are in registers 16 and 17, with slot n at bit (n mod 32) of register 16 + n/32. A slot whose enable is clear emits nothing, whatever its map value.
- R4: Within a lane, enabled slots are emitted in ascending slot order with no idle cycle between accepted bytes. `out_last` marks the final enabled slot of the frame.
- R5: A map offset at or beyond the frame length emits a zero byte.
- R6: Bits 0 to 3 of register 18 enable lanes 0 to 3. A disabled lane emits nothing, and the frame is still released.
- R7: `in_ready` stays low from frame completion until every enabled lane has delivered its bytes. A byte held under back-pressure stays stable.
- R8: Bit 0 of register 19 is the global enable. While it is clear, `in_ready` is low.
- R9: `active` is high while the global enable is set or a frame is still held, and low otherwise.
- R10: Writing 1 to bit 0 of register 20 raises `srst_busy` for one cycle. It then clears capture, lane and hand-off state and the global enable. Map, enables and format are kept.
- R11: A sample with `in_sof` set is stored at frame byte 0 and restarts the sample count, which discards any partial frame.
- R12: After reset, `in_ready`, all `out_valid`, `active` and `srst_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with valid |
| in_sof | input | 1 | Sample is the first of a frame |
| in_data | input | 32 | Input sample, low bytes used for narrow widths |
| out_valid | output | 4 | Per-lane byte valid |
| out_ready | input | 4 | Per-lane byte accept |
| out_data | output | 32 | Lane k byte at bits 8k+7:8k |
| out_last | output | 4 | Per-lane last byte of frame |
| active | output | 1 | Enabled or frame pending |
| srst_busy | output | 1 | Soft reset in progress |

## Verification
The assertions assume that the map, slot enables, lane enables and format are only rewritten while no frame is held. Without that, a lane could lose its current byte or switch off part-way through a frame. The bench therefore changes configuration only once the previous frame has been released, or just before a soft reset. It applies back-pressure only through `out_ready` and never pulls a valid back.

// File: rtl/byte_route_pkg.sv
// Package: shared sizes and register indices for the byte-routing demultiplexer.
// Assumes four lanes of sixteen slots each and 32-bit configuration words.
package byte_route_pkg;
    localparam int NUM_LANES      = 4;
    localparam int SLOTS_PER_LANE = 16;
    localparam int NUM_SLOTS      = NUM_LANES * SLOTS_PER_LANE;
    localparam int WORD_W         = 32;
    localparam int SLOTS_PER_WORD = WORD_W / 8;
    localparam int MAP_WORDS      = NUM_SLOTS / SLOTS_PER_WORD;
    localparam int EN_WORDS       = NUM_SLOTS / WORD_W;
    localparam int MAX_CHANNELS   = 16;
    localparam int MAX_BYTES      = MAX_CHANNELS * (WORD_W / 8);
    localparam int BI_W           = $clog2(MAX_BYTES);
    localparam int FB_W           = BI_W + 1;
    localparam int REG_AW         = 5;

    localparam int REG_SLOT_EN = MAP_WORDS;
    localparam int REG_LANE_EN = REG_SLOT_EN + EN_WORDS;
    localparam int REG_GLOBAL  = REG_LANE_EN + 1;
    localparam int REG_SRST    = REG_GLOBAL + 1;
    localparam int REG_FORMAT  = REG_SRST + 1;

    typedef enum logic [1:0] {
        SW_8  = 2'd0,
        SW_16 = 2'd1,
        SW_32 = 2'd2
    } sample_w_e;
endpackage

// File: rtl/route_cfg_regs.sv
// Module: configuration register file (map, slot enables, lane enables,
// global enable, soft-reset pulse, input format).
// Assumes one write per cycle; a pending soft reset wins over an enable write.
module route_cfg_regs
    import byte_route_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [REG_AW-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    output logic [NUM_SLOTS*8-1:0]   map_flat,
    output logic [NUM_SLOTS-1:0]     slot_en,
    output logic [NUM_LANES-1:0]     lane_en,
    output logic                     glob_en,
    output logic                     srst_q,
    output logic [1:0]               wcode,
    output logic [3:0]               chans_m1
);
    logic [MAP_WORDS-1:0][WORD_W-1:0] map_q;
    logic [EN_WORDS-1:0][WORD_W-1:0]  en_q;

    assign map_flat = map_q;
    assign slot_en  = en_q;

    // Register writes, soft-reset pulse and its clearing of the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q    <= '0;
            en_q     <= '0;
            lane_en  <= '0;
            glob_en  <= 1'b0;
            srst_q   <= 1'b0;
            wcode    <= '0;
            chans_m1 <= '0;
        end else begin
            srst_q <= 1'b0;
            if (we) begin
                if (int'(addr) < MAP_WORDS)
                    map_q[addr[$clog2(MAP_WORDS)-1:0]] <= wdata;
                else if (int'(addr) < REG_SLOT_EN + EN_WORDS)
                    en_q[int'(addr) - REG_SLOT_EN] <= wdata;
                else if (int'(addr) == REG_LANE_EN)
                    lane_en <= wdata[NUM_LANES-1:0];
                else if (int'(addr) == REG_GLOBAL)
                    glob_en <= wdata[0];
                else if (int'(addr) == REG_SRST)
                    srst_q <= wdata[0];
                else if (int'(addr) == REG_FORMAT) begin
                    wcode    <= wdata[1:0];
                    chans_m1 <= wdata[7:4];
                end
            end
            if (srst_q)
                glob_en <= 1'b0;
        end
    end

    // R10: the soft-reset pulse lasts one cycle unless written again
    a_r10_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q && !(we && int'(addr) == REG_SRST) |=> !srst_q)
        else $error("soft reset did not clear itself");

    // R10: a soft reset leaves the block disabled
    a_r10_srst_disables: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !glob_en)
        else $error("global enable survived soft reset");
endmodule

// File: rtl/frame_capture.sv
// Module: packs input samples, low byte first, into a frame byte buffer and
// holds the frame until released. Assumes the format is stable during a frame.
// The buffer contents are not cleared by soft reset.
module frame_capture
    import byte_route_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     accept_en,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic [WORD_W-1:0]        in_data,
    input  logic [1:0]               wcode,
    input  logic [3:0]               chans_m1,
    input  logic                     release_i,
    output logic                     in_ready,
    output logic                     full,
    output logic [FB_W-1:0]          frame_bytes,
    output logic [MAX_BYTES*8-1:0]   buf_flat
);
    logic [MAX_BYTES-1:0][7:0] buf_q;
    logic [FB_W-1:0]           wptr;
    logic [3:0]                cnt;
    logic [2:0]                bps;
    logic [1:0]                wsh;
    logic [FB_W-1:0]           base;
    logic [3:0]                cnt_eff;
    logic                      accept;

    // Sample width code to byte count and shift.
    always_comb begin
        unique case (sample_w_e'(wcode))
            SW_8:    begin bps = 3'd1; wsh = 2'd0; end
            SW_16:   begin bps = 3'd2; wsh = 2'd1; end
            default: begin bps = 3'd4; wsh = 2'd2; end
        endcase
    end

    assign frame_bytes = (FB_W'(chans_m1) + FB_W'(1)) << wsh;
    assign in_ready    = accept_en && !full;
    assign accept      = in_valid && in_ready;
    assign base        = in_sof ? '0 : wptr;
    assign cnt_eff     = in_sof ? '0 : cnt;
    assign buf_flat    = buf_q;

    // Byte buffer write: each used sample byte lands at its frame offset.
    always_ff @(posedge clk) begin
        for (int b = 0; b < WORD_W / 8; b++) begin
            if (accept && 3'(b) < bps && int'(base) + b < MAX_BYTES)
                buf_q[BI_W'(int'(base) + b)] <= in_data[8*b +: 8];
        end
    end

    // Write pointer, sample count and frame-held flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr <= '0;
            cnt  <= '0;
            full <= 1'b0;
        end else if (release_i) begin
            wptr <= '0;
            cnt  <= '0;
            full <= 1'b0;
        end else if (accept) begin
            if (cnt_eff == chans_m1) begin
                full <= 1'b1;
                wptr <= '0;
                cnt  <= '0;
            end else begin
                wptr <= base + FB_W'(bps);
                cnt  <= cnt_eff + 4'd1;
            end
        end
    end

    // R7: a held frame stays held until released or cleared
    a_r7_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        full && !release_i && !clr |=> full)
        else $error("frame dropped without release");
endmodule

// File: rtl/slot_lane.sv
// Module: one output lane. Walks its slots in ascending order, skipping
// disabled slots in zero cycles, and emits the mapped frame byte per slot.
// Assumes map and enables are stable while busy.
module slot_lane
    import byte_route_pkg::*;
#(
    parameter int SLOTS = SLOTS_PER_LANE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     start,
    input  logic                     lane_en,
    input  logic [SLOTS-1:0]         slot_en,
    input  logic [SLOTS*8-1:0]       map_flat,
    input  logic [MAX_BYTES*8-1:0]   buf_flat,
    input  logic [FB_W-1:0]          frame_bytes,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [7:0]               out_data,
    output logic                     out_last,
    output logic                     busy
);
    localparam int SEL_W = $clog2(SLOTS);
    localparam int IDX_W = SEL_W + 1;

    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] sel;
    logic             found;
    logic             more;
    logic [7:0]       off;

    // Find the lowest enabled slot at or above the walk index, and whether another follows.
    always_comb begin
        found = 1'b0;
        more  = 1'b0;
        sel   = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (slot_en[i] && IDX_W'(i) >= idx) begin
                if (found) more = 1'b1;
                else begin
                    found = 1'b1;
                    sel   = SEL_W'(i);
                end
            end
        end
    end

    // Byte fetch from the frame buffer, zero when the offset is past the frame.
    always_comb begin
        off = map_flat[8*int'(sel) +: 8];
        if (off < {1'b0, frame_bytes})
            out_data = buf_flat[{off[BI_W-1:0], 3'b000} +: 8];
        else
            out_data = 8'h00;
    end

    assign out_valid = busy && found;
    assign out_last  = found && !more;

    // Walk state: start on a new frame, advance on accept, finish when no slot remains.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= lane_en;
            idx  <= '0;
        end else if (busy) begin
            if (!found)
                busy <= 1'b0;
            else if (out_ready)
                idx <= {1'b0, sel} + IDX_W'(1);
        end
    end

    // R7: a byte under back-pressure stays put
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !clr |=> out_valid && $stable(out_data))
        else $error("byte changed while stalled");

    // R4: after a non-final byte is taken the next one follows at once
    a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last && !clr |=> out_valid)
        else $error("gap inside a lane frame");
endmodule

// File: rtl/byte_route_demux.sv
// Module: top of the byte-mapped frame demultiplexer. Captures a frame,
// launches all lanes together and releases the frame once every lane is idle.
// Assumes configuration changes only while no frame is held.
module byte_route_demux
    import byte_route_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [REG_AW-1:0]           cfg_addr,
    input  logic [WORD_W-1:0]           cfg_wdata,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_sof,
    input  logic [WORD_W-1:0]           in_data,
    output logic [NUM_LANES-1:0]        out_valid,
    input  logic [NUM_LANES-1:0]        out_ready,
    output logic [NUM_LANES*8-1:0]      out_data,
    output logic [NUM_LANES-1:0]        out_last,
    output logic                        active,
    output logic                        srst_busy
);
    logic [NUM_SLOTS*8-1:0] map_flat;
    logic [NUM_SLOTS-1:0]   slot_en;
    logic [NUM_LANES-1:0]   lane_en;
    logic                   glob_en;
    logic                   srst_q;
    logic [1:0]             wcode;
    logic [3:0]             chans_m1;
    logic                   full;
    logic [FB_W-1:0]        frame_bytes;
    logic [MAX_BYTES*8-1:0] buf_flat;
    logic [NUM_LANES-1:0]   lane_busy;
    logic                   launched;
    logic                   launch;
    logic                   release_w;

    route_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .map_flat(map_flat), .slot_en(slot_en), .lane_en(lane_en), .glob_en(glob_en),
        .srst_q(srst_q), .wcode(wcode), .chans_m1(chans_m1)
    );

    frame_capture u_cap (
        .clk(clk), .rst_n(rst_n), .clr(srst_q), .accept_en(glob_en),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .wcode(wcode), .chans_m1(chans_m1), .release_i(release_w),
        .in_ready(in_ready), .full(full), .frame_bytes(frame_bytes), .buf_flat(buf_flat)
    );

    assign launch    = full && !launched;
    assign release_w = launched && !(|lane_busy);
    assign active    = glob_en || full;
    assign srst_busy = srst_q;

    // Hand-off state: one launch per held frame, cleared on release or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q)
            launched <= 1'b0;
        else if (release_w)
            launched <= 1'b0;
        else if (launch)
            launched <= 1'b1;
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        slot_lane #(.SLOTS(SLOTS_PER_LANE)) u_lane (
            .clk(clk), .rst_n(rst_n), .clr(srst_q), .start(launch),
            .lane_en(lane_en[g]),
            .slot_en(slot_en[g*SLOTS_PER_LANE +: SLOTS_PER_LANE]),
            .map_flat(map_flat[g*SLOTS_PER_LANE*8 +: SLOTS_PER_LANE*8]),
            .buf_flat(buf_flat), .frame_bytes(frame_bytes),
            .out_ready(out_ready[g]), .out_valid(out_valid[g]),
            .out_data(out_data[8*g +: 8]), .out_last(out_last[g]), .busy(lane_busy[g])
        );
    end

    // R7: no new input while any lane is still draining
    a_r7_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_busy) |-> !in_ready)
        else $error("input accepted while lanes busy");

    // R9: an inactive block is silent
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (out_valid == '0) && !in_ready)
        else $error("traffic while inactive");

    // R6: a disabled lane never raises valid
    a_r6_lane_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid & ~lane_en) == '0)
        else $error("disabled lane emitted");
endmodule

// File: tb/byte_route_demux_tb.sv
`timescale 1ns/1ps
module byte_route_demux_tb;
    localparam int A_EN0 = 16, A_EN1 = 17, A_LANE = 18, A_GLOB = 19, A_SRST = 20, A_FMT = 21;
    localparam int NV = 10;
    // {width code, channel count, slot-0 offset}
    localparam logic [14:0] VECS [0:NV-1] = '{
        {2'd0, 5'd4,  8'd2},  {2'd1, 5'd3,  8'd5},  {2'd2, 5'd2,  8'd7},
        {2'd2, 5'd16, 8'd63}, {2'd0, 5'd16, 8'd15}, {2'd0, 5'd16, 8'd16},
        {2'd1, 5'd1,  8'd1},  {2'd1, 5'd1,  8'd2},  {2'd2, 5'd1,  8'd3},
        {2'd0, 5'd1,  8'd200}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic in_valid = 1'b0, in_sof = 1'b0;
    logic [31:0] in_data = '0;
    logic in_ready, active, srst_busy;
    logic [3:0] out_valid, out_last, out_ready;
    logic [31:0] out_data;
    logic [3:0] rdy_base = 4'hF, lfsr = 4'h9;
    logic bp_on = 1'b0;

    int total = 0, bad = 0;
    logic [7:0] map_m [64];
    logic [63:0] en_m;
    logic [3:0] lane_m;
    logic [7:0] got [4][64];
    logic got_last [4][64];
    int gotn [4];

    assign out_ready = bp_on ? lfsr : rdy_base;

    byte_route_demux u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .active(active), .srst_busy(srst_busy)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk); #1;
        lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    end

    initial forever begin
        @(negedge clk);
        for (int l = 0; l < 4; l++)
            if (out_valid[l] && out_ready[l] && gotn[l] < 64) begin
                got[l][gotn[l]] = out_data[8*l +: 8];
                got_last[l][gotn[l]] = out_last[l];
                gotn[l]++;
            end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((i * 7 + seed) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic push_cfg();
        for (int w = 0; w < 16; w++)
            cfg_write(w, {map_m[4*w+3], map_m[4*w+2], map_m[4*w+1], map_m[4*w]});
        cfg_write(A_EN0, en_m[31:0]);
        cfg_write(A_EN1, en_m[63:32]);
        cfg_write(A_LANE, {28'b0, lane_m});
    endtask

    task automatic clear_mon();
        for (int l = 0; l < 4; l++) gotn[l] = 0;
    endtask

    task automatic send_frame(input int seed, input int bps, input int nsamp);
        @(posedge clk); #1;
        for (int k = 0; k < nsamp; k++) begin
            in_valid = 1'b1;
            in_sof = (k == 0);
            for (int j = 0; j < 4; j++)
                in_data[8*j +: 8] = (j < bps) ? pat(seed, k * bps + j) : 8'hEE;
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic wait_release();
        int n = 0;
        @(negedge clk);
        while (!in_ready && n < 3000) begin @(negedge clk); n++; end
        chk(in_ready, "R7 frame release", in_ready, 1);
    endtask

    task automatic check_lanes(input int seed, input int fb, input string tag);
        for (int l = 0; l < 4; l++) begin
            logic [7:0] e [16];
            int n = 0;
            for (int s = 0; s < 16; s++)
                if (en_m[l*16+s] && lane_m[l]) begin
                    e[n] = (int'(map_m[l*16+s]) < fb) ? pat(seed, int'(map_m[l*16+s])) : 8'h00;
                    n++;
                end
            chk(gotn[l] == n, {tag, " byte count"}, gotn[l], n);
            for (int i = 0; i < n && i < gotn[l]; i++) begin
                chk(got[l][i] == e[i], {tag, " byte"}, got[l][i], e[i]);
                chk(got_last[l][i] == (i == n - 1), {tag, " R4 last flag"}, got_last[l][i], (i == n - 1));
            end
        end
    endtask

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(in_ready == 0, "R12 in_ready", in_ready, 0);
        chk(out_valid == 0, "R12 out_valid", out_valid, 0);
        chk(active == 0 && srst_busy == 0, "R12 status", {active, srst_busy}, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Table walk: R1 packing, R2 routing, R5 out-of-frame zero
        for (int v = 0; v < 64; v++) map_m[v] = 8'h00;
        en_m = 64'h1; lane_m = 4'h1;
        push_cfg();
        cfg_write(A_GLOB, 32'h1);
        for (int v = 0; v < NV; v++) begin
            int wc = int'(VECS[v][14:13]);
            int ch = int'(VECS[v][12:8]);
            int bps = (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
            int seed = v * 11 + 5;
            map_m[0] = VECS[v][7:0];
            cfg_write(0, {24'b0, map_m[0]});
            cfg_write(A_FMT, {24'b0, 4'(ch - 1), 2'b0, 2'(wc)});
            clear_mon();
            send_frame(seed, bps, ch);
            wait_release();
            check_lanes(seed, ch * bps, "R1 R2 R5 table");
        end

        // Sparse enables, reversed map, disabled lane, back-pressure: R2 R3 R6 R7
        for (int s = 0; s < 64; s++) map_m[s] = 8'(63 - s);
        en_m = {32'h4000_0003, 32'h8001_0005};
        lane_m = 4'b0111;
        push_cfg();
        cfg_write(A_FMT, {24'b0, 4'd15, 2'b0, 2'd2});
        clear_mon();
        bp_on = 1'b1;
        send_frame(77, 4, 16);
        @(negedge clk);
        chk(in_ready == 0, "R7 ready low while draining", in_ready, 0);
        wait_release();
        bp_on = 1'b0;
        check_lanes(77, 64, "R3 R6 sparse");

        // Start-of-frame realigns a partial frame: R11
        for (int s = 0; s < 4; s++) map_m[s] = 8'(s);
        en_m = 64'hF; lane_m = 4'h1;
        push_cfg();
        cfg_write(A_FMT, {24'b0, 4'd3, 2'b0, 2'd0});
        clear_mon();
        send_frame(200, 1, 2);
        send_frame(31, 1, 4);
        wait_release();
        check_lanes(31, 4, "R11 sof realign");

        // Global enable: R8 R9
        cfg_write(A_GLOB, 32'h0);
        @(negedge clk);
        chk(active == 0, "R9 inactive when idle and disabled", active, 0);
        @(posedge clk); #1 in_valid = 1'b1; in_sof = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 4; i++) begin @(negedge clk); seen |= int'(in_ready); end
            chk(seen == 0, "R8 no ready while disabled", seen, 0);
        end
        @(posedge clk); #1 in_valid = 1'b0; in_sof = 1'b0;
        cfg_write(A_GLOB, 32'h1);
        @(negedge clk);
        chk(active == 1, "R9 active when enabled", active, 1);

        // Soft reset with a stalled frame, then reuse of kept config: R10 R4
        for (int s = 0; s < 64; s++) map_m[s] = 8'((s * 5 + 3) & 63);
        en_m = {64{1'b1}}; lane_m = 4'hF;
        push_cfg();
        cfg_write(A_FMT, {24'b0, 4'd15, 2'b0, 2'd2});
        rdy_base = 4'h0;
        clear_mon();
        send_frame(9, 4, 16);
        repeat (3) @(negedge clk);
        chk(active == 1 && out_valid == 4'hF, "R10 stalled before reset", {active, out_valid}, 5'h1F);
        cfg_write(A_SRST, 32'h1);
        @(negedge clk);
        chk(srst_busy == 1, "R10 busy pulse", srst_busy, 1);
        @(negedge clk);
        chk(srst_busy == 0, "R10 self clear", srst_busy, 0);
        chk(out_valid == 0 && in_ready == 0 && active == 0, "R10 cleared state",
            {out_valid, in_ready, active}, 0);
        rdy_base = 4'hF;
        cfg_write(A_GLOB, 32'h1);
        clear_mon();
        send_frame(123, 4, 16);
        wait_release();
        check_lanes(123, 64, "R10 R4 full map kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule